// File: doc/BRIEF.md
# Flag-Conditioned Hardware Loop Controller

This block sits beside the fetch stage and repeats a block of instructions without a branch instruction being fetched again on every pass. A single setup command, seen once, gives the address of the setup instruction, the number of instructions that follow it and form the body, one of four condition flags to test, and an exit polarity. From then on the controller compares the fetch program counter with the last address of the body. At that address it either steers the next fetch back to the first body address or lets fetch fall through to the instruction after the body, which also ends the loop.

The decision reads a four-bit condition flag register. Each executed instruction carries a write-enable bit, and only instructions with that bit set replace the flags, so the loop may test a result produced well before the end of the body. A redirect raised elsewhere in the pipeline (taken branch, exception, flush) cancels the loop at once. Program counters count instructions, so sequential fetch advances by one.

Top module: `hwloop_ctrl`

## Requirements
- R1: During and after reset `loop_active` is 0, the flag register holds 0000, and `next_pc` equals `fetch_pc + 1`.
- R2: A setup with a nonzero length and no redirect sets `loop_active` at the next clock edge, with body start `setup_pc + 1` and body end `setup_pc + setup_len`.
- R3: A setup with length 0 is ignored: `loop_active` and any previously loaded loop keep their values.
- R4: While active, when `fetch_pc` equals the body end and the condition says repeat, `next_pc` is the body start in that same cycle and `loop_active` stays 1.
- R5: While active, when `fetch_pc` equals the body end and the condition says exit, `next_pc` is body end + 1 and `loop_active` is 0 after the clock edge.
- R6: When the loop is inactive, or `fetch_pc` is not the body end, `next_pc` is `fetch_pc + 1`.
- R7: The flag register takes `flag_in` at a clock edge only when `flag_we` is 1; otherwise it keeps its value. The loop decision uses the register as it stood before the current edge.
- R8: Flag bits are 0 sign, 1 zero, 2 carry, 3 overflow; `setup_flag_sel` is the bit index. The body repeats when the selected bit differs from `setup_polarity` (polarity 0: repeat while set; polarity 1: repeat while clear).
- R9: `redirect` clears `loop_active` at the next edge, overrides a setup in the same cycle, and while high `next_pc` is `fetch_pc + 1`.
- R10: A nonzero-length setup while a loop is active replaces start, end, flag selection and polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| setup_valid | input | 1 | Loop setup command present this cycle |
| setup_pc | input | 32 | Address of the setup instruction |
| setup_len | input | 8 | Number of body instructions after the setup |
| setup_flag_sel | input | 2 | Index of the flag bit tested at body end |
| setup_polarity | input | 1 | Exit polarity (0 repeat while set, 1 repeat while clear) |
| flag_we | input | 1 | Current instruction is a flag writer |
| flag_in | input | 4 | Flags produced by that instruction |
| fetch_pc | input | 32 | Current fetch address |
| redirect | input | 1 | Flush or redirect from elsewhere in the pipeline |
| next_pc | output | 32 | Next fetch address chosen by the loop logic |
| loop_active | output | 1 | A hardware loop is in progress |

## Verification
Every cycle the assertions check that flags change only on a write and then hold the written value, that a redirect always ends the loop, that a zero-length setup never starts one while a valid setup does, and that fetch runs sequentially whenever the body end is not being fetched. The choice between returning to the body start and falling through, including the effect of each flag index and polarity, of flags written many instructions earlier, and of a setup that replaces a running loop, is shown only by the bench's directed sequences and its random fetch streams compared against a bench model.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  localparam int NUM_FLAGS = 4;
  localparam int SEL_W     = $clog2(NUM_FLAGS);

  typedef logic [NUM_FLAGS-1:0] flags_t;   // [0] sign [1] zero [2] carry [3] overflow
  typedef logic [SEL_W-1:0]     flag_sel_t;

  // Repeat when the chosen flag differs from the exit polarity.
  function automatic logic loop_repeat(input flags_t f, input flag_sel_t sel, input logic pol);
    return f[sel] ^ pol;
  endfunction
endpackage

// File: rtl/hwloop_rst_sync.sv
module hwloop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/hwloop_flags.sv
module hwloop_flags
  import hwloop_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  flags_t wr_data,
  output flags_t flags_q
);
  flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (wr_en) flags_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/hwloop_regs.sv
module hwloop_regs
  import hwloop_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_valid,
  input  logic [PC_W-1:0]  setup_pc,
  input  logic [LEN_W-1:0] setup_len,
  input  flag_sel_t        setup_sel,
  input  logic             setup_pol,
  input  logic             redirect,
  input  logic             exit_taken,
  output logic             active_q,
  output logic [PC_W-1:0]  start_q,
  output logic [PC_W-1:0]  end_q,
  output flag_sel_t        sel_q,
  output logic             pol_q
);
  logic            load_en;
  logic            active_d;
  logic [PC_W-1:0] start_d, end_d;

  // Zero-length setups and squashed setups never load.
  assign load_en = setup_valid && (setup_len != '0) && !redirect;
  assign start_d = setup_pc + PC_W'(1);
  assign end_d   = setup_pc + PC_W'(setup_len);

  always_comb begin
    active_d = active_q;
    if (redirect)        active_d = 1'b0;
    else if (load_en)    active_d = 1'b1;
    else if (exit_taken) active_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      sel_q   <= '0;
      pol_q   <= 1'b0;
    end else if (load_en) begin
      start_q <= start_d;
      end_q   <= end_d;
      sel_q   <= setup_sel;
      pol_q   <= setup_pol;
    end
  end
endmodule

// File: rtl/hwloop_nextpc.sv
module hwloop_nextpc
  import hwloop_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            active,
  input  logic            redirect,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic [PC_W-1:0] start_addr,
  input  logic [PC_W-1:0] end_addr,
  input  flags_t          flags,
  input  flag_sel_t       sel,
  input  logic            pol,
  output logic [PC_W-1:0] next_pc,
  output logic            exit_taken
);
  logic at_end;
  logic again;

  assign at_end = active && !redirect && (fetch_pc == end_addr);
  assign again  = loop_repeat(flags, sel, pol);

  always_comb begin
    next_pc    = fetch_pc + PC_W'(1);
    exit_taken = 1'b0;
    if (at_end) begin
      if (again) begin
        next_pc = start_addr;
      end else begin
        next_pc    = end_addr + PC_W'(1);
        exit_taken = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwloop_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_valid,
  input  logic [PC_W-1:0]  setup_pc,
  input  logic [LEN_W-1:0] setup_len,
  input  logic [1:0]       setup_flag_sel,
  input  logic             setup_polarity,
  input  logic             flag_we,
  input  logic [3:0]       flag_in,
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic             redirect,
  output logic [PC_W-1:0]  next_pc,
  output logic             loop_active
);
  logic            rst_int_n;
  flags_t          flags_q;
  logic [PC_W-1:0] start_q, end_q;
  flag_sel_t       sel_q;
  logic            pol_q;
  logic            exit_taken;

  hwloop_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  hwloop_flags u_flags (
    .clk(clk), .rst_n(rst_int_n), .wr_en(flag_we), .wr_data(flag_in), .flags_q(flags_q)
  );

  hwloop_regs #(.PC_W(PC_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .setup_valid(setup_valid), .setup_pc(setup_pc), .setup_len(setup_len),
    .setup_sel(setup_flag_sel), .setup_pol(setup_polarity),
    .redirect(redirect), .exit_taken(exit_taken),
    .active_q(loop_active), .start_q(start_q), .end_q(end_q),
    .sel_q(sel_q), .pol_q(pol_q)
  );

  hwloop_nextpc #(.PC_W(PC_W)) u_npc (
    .active(loop_active), .redirect(redirect), .fetch_pc(fetch_pc),
    .start_addr(start_q), .end_addr(end_q), .flags(flags_q),
    .sel(sel_q), .pol(pol_q), .next_pc(next_pc), .exit_taken(exit_taken)
  );
endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk #(
  parameter int PC_W  = 32,
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             setup_valid,
  input logic [LEN_W-1:0] setup_len,
  input logic             flag_we,
  input logic [3:0]       flag_in,
  input logic [3:0]       flags_q,
  input logic [PC_W-1:0]  fetch_pc,
  input logic [PC_W-1:0]  end_q,
  input logic             redirect,
  input logic [PC_W-1:0]  next_pc,
  input logic             loop_active
);
  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !flag_we |=> $stable(flags_q));

  assert_flags_write_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    flag_we |=> flags_q == $past(flag_in));

  assert_redirect_clears_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    redirect |=> !loop_active);

  assert_redirect_seq_pc_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    redirect |-> next_pc == fetch_pc + PC_W'(1));

  assert_zero_len_idle_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (setup_valid && setup_len == '0 && !loop_active) |=> !loop_active);

  assert_setup_starts_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (setup_valid && setup_len != '0 && !redirect) |=> loop_active);

  assert_sequential_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!loop_active || fetch_pc != end_q) |-> next_pc == fetch_pc + PC_W'(1));
endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.PC_W(PC_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .setup_valid(setup_valid), .setup_len(setup_len),
  .flag_we(flag_we), .flag_in(flag_in), .flags_q(flags_q), .fetch_pc(fetch_pc),
  .end_q(end_q), .redirect(redirect), .next_pc(next_pc), .loop_active(loop_active)
);

// File: tb/hwloop_ctrl_tb.sv
module hwloop_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        setup_valid, setup_polarity, flag_we, redirect;
  logic [31:0] setup_pc, fetch_pc, next_pc;
  logic [7:0]  setup_len;
  logic [1:0]  setup_flag_sel;
  logic [3:0]  flag_in;
  logic        loop_active;

  int n_chk = 0, n_bad = 0;

  // bench model state
  logic        m_act;
  logic [31:0] m_start, m_end;
  logic [1:0]  m_sel;
  logic        m_pol;
  logic [3:0]  m_flags;
  logic [31:0] pc_follow;

  hwloop_ctrl u_dut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_next(input logic [31:0] pc, input logic redir);
    if (!redir && m_act && pc == m_end)
      return ((m_flags[m_sel] != m_pol) ? m_start : m_end + 32'd1);
    return pc + 32'd1;
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One cycle: check state, drive, check next_pc, advance model.
  task automatic step(input logic sv, input logic [31:0] spc, input logic [7:0] len,
                      input logic [1:0] sel, input logic pol, input logic fwe,
                      input logic [3:0] fin, input logic [31:0] pc, input logic redir,
                      input string tag);
    logic [31:0] e;
    @(negedge clk);
    chk(loop_active == m_act, tag, "loop_active", 32'(loop_active), 32'(m_act));
    setup_valid = sv; setup_pc = spc; setup_len = len; setup_flag_sel = sel;
    setup_polarity = pol; flag_we = fwe; flag_in = fin; fetch_pc = pc; redirect = redir;
    #1;
    e = exp_next(pc, redir);
    chk(next_pc == e, tag, "next_pc", next_pc, e);
    if (redir) m_act = 1'b0;
    else if (sv && len != 8'd0) begin
      m_act = 1'b1; m_start = spc + 32'd1; m_end = spc + 32'(len); m_sel = sel; m_pol = pol;
    end else if (m_act && pc == m_end && m_flags[m_sel] == m_pol) m_act = 1'b0;
    if (fwe) m_flags = fin;
    pc_follow = (sv && len != 8'd0 && !redir) ? spc + 32'd1 : e;
  endtask

  task automatic idle(input logic [31:0] pc, input string tag);
    step(1'b0, 32'd0, 8'd0, 2'd0, 1'b0, 1'b0, 4'd0, pc, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic        sv, fwe, rd, pol;
    logic [31:0] spc, pc;
    logic [7:0]  len;
    logic [1:0]  sel;
    logic [3:0]  fin;
    void'($urandom(32'd4242));
    m_act = 0; m_start = 0; m_end = 0; m_sel = 0; m_pol = 0; m_flags = 0; pc_follow = 0;
    setup_valid = 0; setup_pc = 0; setup_len = 0; setup_flag_sel = 0; setup_polarity = 0;
    flag_we = 0; flag_in = 0; fetch_pc = 0; redirect = 0;
    rst_n = 1'b0;
    // R1: reset state, loop commands held off by reset
    idle(32'd10, "R1");
    idle(32'd0, "R1");
    @(negedge clk); rst_n = 1'b1;
    idle(32'd20, "R1");
    idle(32'hFFFF_FFFF, "R1");
    idle(32'd5, "R1");

    // R2/R4: sign flag set, polarity 0 -> repeat
    step(0, 0, 0, 0, 0, 1, 4'b0001, 32'd50, 0, "R7");
    step(1, 32'd100, 8'd3, 2'd0, 1'b0, 0, 0, 32'd51, 0, "R2");
    idle(32'd101, "R2");
    idle(32'd102, "R6");
    idle(32'd103, "R4");
    // R7: a non-writer with different data keeps the old flags
    step(0, 0, 0, 0, 0, 0, 4'b0000, 32'd101, 0, "R7");
    idle(32'd102, "R6");
    idle(32'd103, "R7");
    // R5: writer clears sign -> exit
    step(0, 0, 0, 0, 0, 1, 4'b0000, 32'd101, 0, "R7");
    idle(32'd102, "R6");
    idle(32'd103, "R5");
    idle(32'd104, "R5");
    // R3: zero-length setup when idle
    step(1, 32'd200, 8'd0, 2'd0, 1'b0, 0, 0, 32'd200, 0, "R3");
    idle(32'd200, "R3");
    // R8: carry (bit 2) clear, polarity 1 -> repeat while clear
    step(1, 32'd300, 8'd2, 2'd2, 1'b1, 1, 4'b1011, 32'd300, 0, "R8");
    idle(32'd301, "R8");
    idle(32'd302, "R8");
    // R3: zero-length setup while active keeps loop
    step(1, 32'd900, 8'd0, 2'd0, 1'b0, 0, 0, 32'd301, 0, "R3");
    idle(32'd302, "R3");
    // R10: reload while active; overflow bit 3 set, pol 0
    step(1, 32'd400, 8'd1, 2'd3, 1'b0, 0, 0, 32'd301, 0, "R10");
    idle(32'd302, "R10");
    idle(32'd401, "R10");
    // R9: redirect at body end, and redirect overriding a setup
    step(0, 0, 0, 0, 0, 0, 0, 32'd401, 1, "R9");
    idle(32'd401, "R9");
    step(1, 32'd500, 8'd4, 2'd1, 1'b0, 0, 0, 32'd77, 1, "R9");
    idle(32'd504, "R9");
    // R8: zero flag (bit 1) set, polarity 1 -> exit
    step(1, 32'd600, 8'd1, 2'd1, 1'b1, 1, 4'b0010, 32'd600, 0, "R8");
    idle(32'd601, "R8");
    idle(32'd602, "R5");

    // constrained random fetch streams
    for (int i = 0; i < 4000; i++) begin
      sv  = ($urandom % 20) == 0;
      spc = $urandom % 64;
      len = ($urandom % 8 == 0) ? 8'd0 : 8'($urandom % 6 + 1);
      sel = 2'($urandom);
      pol = 1'($urandom);
      fwe = ($urandom % 3) == 0;
      fin = 4'($urandom);
      rd  = ($urandom % 40) == 0;
      pc  = ($urandom % 12 == 0) ? ($urandom % 80) : pc_follow;
      step(sv, spc, len, sel, pol, fwe, fin, pc, rd, "R4/R5 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule